// File: doc/BRIEF.md
# Video Sync Measurement and Power-State Detector

This block watches the horizontal and vertical sync inputs of a display controller. Each sync line passes through a two-flop synchroniser before its rising edges are detected. For each line the block reports whether it is present and which polarity its pulse has. It counts horizontal pulses over a fixed measurement window. It measures the vertical period in units of a fixed timebase tick. From the two presence bits it derives one of four display power states.

The timebase divides the system clock down to an 8 us tick, using the clock frequency given as a parameter. A window is WIN_TICKS ticks long; 1024 ticks give 8.192 ms. Firmware reads the values through a small register port. Reads are combinational on `rd_addr`. Writes take effect on the clock edge at which `wr_en` is high. The horizontal count is copied into a read register at each window end, so a read always returns a settled value. The overflow flags stay set until firmware writes a one to the matching clear bit.

Top module: `sync_mode_monitor`

## Requirements
- R1: The vertical measurement advances once per timebase tick. A tick lasts CLK_FREQ_HZ/TICK_RATE_HZ clocks, and a window lasts WIN_TICKS ticks.
- R2: At each window end, the number of HSYNC rising edges seen during that window is latched. It reads as the low byte at address 1 and the high bits, zero-extended, at address 2.
- R3: If an HSYNC edge arrives while the horizontal counter holds 2^CNT_W-1, status bit 4 sets and the counter stays at its maximum. The bit stays set until it is cleared.
- R4: Writing address 6 with bit 0 set clears status bit 4 and restarts the horizontal counter from zero. Bit 1 clears status bit 5 and restarts the vertical counter. A zero in either bit leaves the flag unchanged.
- R5: Control bit 0 at address 5 is the horizontal enable; it is 1 after reset and reads back. While it is 0, the horizontal counter is held at zero, so windows latch a count of 0.
- R6: The number of ticks between consecutive VSYNC rising edges is latched at each rising edge. It reads at addresses 3 (low byte) and 4 (high bits). If the counter reaches 2^CNT_W-1 with no edge, status bit 5 sets and stays set until it is cleared.
- R7: Status bits 0 (H) and 1 (V) are 1 when at least one rising edge was seen in the last completed window. They change only at window ends.
- R8: Status bits 2 (H) and 3 (V) read 1 when the sync is high for less time than it is low over a period (positive pulse), and 0 otherwise. They update at each rising edge.
- R9: Status bits 7:6 give the power state: 00 normal (both present), 01 standby (H absent, V present), 10 suspend (H present, V absent), 11 off (both absent).
- R10: After reset the status reads 0xC0, both counts read 0 and the control register reads 0x01.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_in | input | 1 | Raw horizontal sync |
| vsync_in | input | 1 | Raw vertical sync |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Read data for rd_addr |

## Verification
The assertions check the following on every cycle:
- Both overflow flags stay set until a clear write arrives.
- A clear write zeroes its counter.
- A disabled horizontal counter stays at zero.
- A vertical rising edge restarts the period counter.
- The latched period holds between edges.
- The presence bits move only at window ends.

Only the bench scenarios can show that the counts match the stimulus periods, that polarity follows the duty cycle, and that all four power states decode correctly from real sync patterns.

// File: rtl/sync_mon_pkg.sv
package sync_mon_pkg;

    typedef enum logic [1:0] {
        PWR_NORMAL  = 2'b00,
        PWR_STANDBY = 2'b01,
        PWR_SUSPEND = 2'b10,
        PWR_OFF     = 2'b11
    } pwr_state_e;

    localparam logic [2:0] ADDR_STATUS  = 3'd0;
    localparam logic [2:0] ADDR_HCNT_LO = 3'd1;
    localparam logic [2:0] ADDR_HCNT_HI = 3'd2;
    localparam logic [2:0] ADDR_VCNT_LO = 3'd3;
    localparam logic [2:0] ADDR_VCNT_HI = 3'd4;
    localparam logic [2:0] ADDR_CTRL    = 3'd5;
    localparam logic [2:0] ADDR_CLEAR   = 3'd6;

endpackage

// File: rtl/sync_mon_timebase.sv
module sync_mon_timebase #(
    parameter int CLK_PER_TICK = 192,
    parameter int WIN_TICKS    = 1024
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick,
    output logic win_end
);
    localparam int PW = (CLK_PER_TICK > 1) ? $clog2(CLK_PER_TICK) : 1;
    localparam int WW = (WIN_TICKS > 1) ? $clog2(WIN_TICKS) : 1;

    typedef struct packed {
        logic [PW-1:0] presc;
        logic [WW-1:0] win;
    } tb_state_t;

    tb_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        tick    = (st_q.presc == PW'(CLK_PER_TICK - 1));
        win_end = tick && (st_q.win == WW'(WIN_TICKS - 1));
        st_d.presc = tick ? '0 : st_q.presc + PW'(1);
        if (tick) begin
            st_d.win = win_end ? '0 : st_q.win + WW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/sync_mon_channel.sv
module sync_mon_channel #(
    parameter int POL_W = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_raw,
    input  logic win_end,
    output logic rise,
    output logic active,
    output logic pol_pos
);
    localparam logic [POL_W-1:0] ACC_MAX = {1'b0, {(POL_W-1){1'b1}}};
    localparam logic [POL_W-1:0] ACC_MIN = {1'b1, {(POL_W-1){1'b0}}};

    typedef struct packed {
        logic             s1;
        logic             s2;
        logic             s3;
        logic             seen;
        logic             active;
        logic             pol;
        logic [POL_W-1:0] acc;
    } ch_state_t;

    ch_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        rise    = st_q.s2 & ~st_q.s3;
        st_d.s1 = sync_raw;
        st_d.s2 = st_q.s1;
        st_d.s3 = st_q.s2;
        // duty balance: up while high, down while low, saturating
        if (rise) begin
            st_d.pol = st_q.acc[POL_W-1];
            st_d.acc = '0;
        end else if (st_q.s2) begin
            if (st_q.acc != ACC_MAX) st_d.acc = st_q.acc + POL_W'(1);
        end else begin
            if (st_q.acc != ACC_MIN) st_d.acc = st_q.acc - POL_W'(1);
        end
        if (win_end) begin
            st_d.active = st_q.seen | rise;
            st_d.seen   = 1'b0;
        end else begin
            st_d.seen = st_q.seen | rise;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active  = st_q.active;
    assign pol_pos = st_q.pol;
endmodule

// File: rtl/sync_mode_monitor.sv
module sync_mode_monitor
    import sync_mon_pkg::*;
#(
    parameter int CLK_FREQ_HZ  = 24_000_000,
    parameter int TICK_RATE_HZ = 125_000,
    parameter int WIN_TICKS    = 1024,
    parameter int CNT_W        = 12,
    parameter int POL_W        = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hsync_in,
    input  logic       vsync_in,
    input  logic       wr_en,
    input  logic [2:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic [2:0] rd_addr,
    output logic [7:0] rd_data
);
    localparam int CLK_PER_TICK = CLK_FREQ_HZ / TICK_RATE_HZ;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic             h_run;
        logic [CNT_W-1:0] h_cnt;
        logic [CNT_W-1:0] h_read;
        logic             h_ovf;
        logic [CNT_W-1:0] v_cnt;
        logic [CNT_W-1:0] v_read;
        logic             v_ovf;
    } top_state_t;

    localparam top_state_t RESET_ST = '{h_run: 1'b1, default: '0};

    top_state_t st_d, st_q;

    logic       tick, win_end;
    logic [1:0] sync_raw, rise, act, pol;
    logic       wr_ctrl, clr_h, clr_v;
    pwr_state_e pwr;

    assign sync_raw = {vsync_in, hsync_in};

    sync_mon_timebase #(
        .CLK_PER_TICK (CLK_PER_TICK),
        .WIN_TICKS    (WIN_TICKS)
    ) timebase_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .win_end (win_end)
    );

    for (genvar g = 0; g < 2; g++) begin : g_chan
        sync_mon_channel #(.POL_W(POL_W)) chan_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .sync_raw (sync_raw[g]),
            .win_end  (win_end),
            .rise     (rise[g]),
            .active   (act[g]),
            .pol_pos  (pol[g])
        );
    end

    always_comb begin
        wr_ctrl = wr_en && (wr_addr == ADDR_CTRL);
        clr_h   = wr_en && (wr_addr == ADDR_CLEAR) && wr_data[0];
        clr_v   = wr_en && (wr_addr == ADDR_CLEAR) && wr_data[1];
        st_d    = st_q;

        if (wr_ctrl) st_d.h_run = wr_data[0];

        // horizontal pulse count per window
        if (win_end) st_d.h_read = st_q.h_cnt;
        if (!st_q.h_run || clr_h) begin
            st_d.h_cnt = '0;
        end else if (win_end) begin
            st_d.h_cnt = rise[0] ? CNT_W'(1) : '0;
        end else if (rise[0]) begin
            if (st_q.h_cnt == CNT_MAX) st_d.h_ovf = 1'b1;
            else                       st_d.h_cnt = st_q.h_cnt + CNT_W'(1);
        end
        if (clr_h) st_d.h_ovf = 1'b0;

        // vertical period in ticks
        if (clr_v) begin
            st_d.v_cnt = '0;
        end else if (rise[1]) begin
            st_d.v_read = st_q.v_cnt;
            st_d.v_cnt  = '0;
        end else if (tick) begin
            if (st_q.v_cnt == CNT_MAX) st_d.v_ovf = 1'b1;
            else                       st_d.v_cnt = st_q.v_cnt + CNT_W'(1);
        end
        if (clr_v) st_d.v_ovf = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RESET_ST;
        else        st_q <= st_d;
    end

    // aliases for the bound checker
    logic             h_run_q, h_ovf_q, v_ovf_q;
    logic [CNT_W-1:0] h_cnt_q, v_cnt_q, v_read_q;
    assign h_run_q  = st_q.h_run;
    assign h_ovf_q  = st_q.h_ovf;
    assign v_ovf_q  = st_q.v_ovf;
    assign h_cnt_q  = st_q.h_cnt;
    assign v_cnt_q  = st_q.v_cnt;
    assign v_read_q = st_q.v_read;

    logic [15:0] h_ext, v_ext;
    assign h_ext = 16'(st_q.h_read);
    assign v_ext = 16'(st_q.v_read);

    always_comb begin
        pwr = pwr_state_e'({~act[1], ~act[0]});
        case (rd_addr)
            ADDR_STATUS:  rd_data = {pwr, st_q.v_ovf, st_q.h_ovf, pol[1], pol[0], act[1], act[0]};
            ADDR_HCNT_LO: rd_data = h_ext[7:0];
            ADDR_HCNT_HI: rd_data = {4'b0, h_ext[11:8]};
            ADDR_VCNT_LO: rd_data = v_ext[7:0];
            ADDR_VCNT_HI: rd_data = {4'b0, v_ext[11:8]};
            ADDR_CTRL:    rd_data = {7'b0, st_q.h_run};
            default:      rd_data = 8'h00;
        endcase
    end
endmodule

// File: rtl/sync_mode_monitor_chk.sv
module sync_mode_monitor_chk #(
    parameter int CNT_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr_h,
    input logic             clr_v,
    input logic             win_end,
    input logic             v_rise,
    input logic             h_run_q,
    input logic             h_ovf_q,
    input logic             v_ovf_q,
    input logic [CNT_W-1:0] h_cnt_q,
    input logic [CNT_W-1:0] v_cnt_q,
    input logic [CNT_W-1:0] v_read_q,
    input logic [1:0]       act
);
    p_hovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (h_ovf_q && !clr_h) |=> h_ovf_q);

    p_vovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (v_ovf_q && !clr_v) |=> v_ovf_q);

    p_hclear_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clr_h |=> (h_cnt_q == '0 && !h_ovf_q));

    p_vclear_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clr_v |=> (v_cnt_q == '0 && !v_ovf_q));

    p_hold_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !h_run_q |=> (h_cnt_q == '0));

    p_vcnt_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        v_rise |=> (v_cnt_q == '0));

    p_vread_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !v_rise |=> $stable(v_read_q));

    p_act_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !win_end |=> $stable(act));
endmodule

bind sync_mode_monitor sync_mode_monitor_chk #(.CNT_W(CNT_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_h    (clr_h),
    .clr_v    (clr_v),
    .win_end  (win_end),
    .v_rise   (rise[1]),
    .h_run_q  (h_run_q),
    .h_ovf_q  (h_ovf_q),
    .v_ovf_q  (v_ovf_q),
    .h_cnt_q  (h_cnt_q),
    .v_cnt_q  (v_cnt_q),
    .v_read_q (v_read_q),
    .act      (act)
);

// File: tb/sync_mode_monitor_tb_top.sv
module sync_mode_monitor_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WIN_TICKS  = 2200;
    localparam int CNT_W      = 10;
    localparam int WIN_CLKS   = WIN_TICKS * 2;
    localparam int RUN_CLKS   = 2 * WIN_CLKS + 500;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hsync = 1'b0, vsync = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0, rd_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;

    int n_checks = 0, n_bad = 0;
    bit finished = 0, mon_busy = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sync_mode_monitor #(
        .CLK_FREQ_HZ (250_000),
        .WIN_TICKS   (WIN_TICKS),
        .CNT_W       (CNT_W),
        .POL_W       (16)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .hsync_in (hsync), .vsync_in (vsync),
        .wr_en (wr_en), .wr_addr (wr_addr), .wr_data (wr_data),
        .rd_addr (rd_addr), .rd_data (rd_data)
    );

    // sync pattern generators
    int h_en = 0, h_per = 8, h_hi = 2, h_ph = 0;
    int v_en = 0, v_per = 1000, v_hi = 50, v_ph = 0;
    initial forever begin
        @(negedge clk);
        if (h_en != 0) begin
            hsync = (h_ph < h_hi);
            h_ph  = (h_ph + 1 >= h_per) ? 0 : h_ph + 1;
        end else hsync = 1'b0;
        if (v_en != 0) begin
            vsync = (v_ph < v_hi);
            v_ph  = (v_ph + 1 >= v_per) ? 0 : v_ph + 1;
        end else vsync = 1'b0;
    end

    typedef struct {
        bit         is_cnt;
        logic [2:0] addr;
        int         exp;
        logic [7:0] mask;
        int         tol;
        string      tag;
    } sb_item_t;

    sb_item_t sb_q[$];

    task automatic exp_reg(input logic [2:0] a, input logic [7:0] e,
                           input logic [7:0] m, input string tag);
        sb_item_t it;
        it.is_cnt = 0; it.addr = a; it.exp = int'(e); it.mask = m; it.tol = 0; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic exp_cnt(input logic [2:0] a, input int e, input int tol, input string tag);
        sb_item_t it;
        it.is_cnt = 1; it.addr = a; it.exp = e; it.mask = 8'hFF; it.tol = tol; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic drain();
        wait (sb_q.size() == 0 && mon_busy == 0);
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: pops expectations and compares against the read port
    initial forever begin
        sb_item_t it;
        int got, diff;
        logic [7:0] lo;
        wait (sb_q.size() != 0);
        mon_busy = 1;
        it = sb_q.pop_front();
        @(negedge clk);
        rd_addr = it.addr;
        @(negedge clk);
        n_checks++;
        if (it.is_cnt) begin
            lo = rd_data;
            rd_addr = it.addr + 3'd1;
            @(negedge clk);
            got  = int'({rd_data[3:0], lo});
            diff = (got > it.exp) ? got - it.exp : it.exp - got;
            if (diff > it.tol) begin
                n_bad++;
                $display("FAIL %s: count actual=%0d expected=%0d (tol %0d)", it.tag, got, it.exp, it.tol);
            end
        end else begin
            got = int'(rd_data);
            if (((rd_data ^ it.exp[7:0]) & it.mask) != 8'h00) begin
                n_bad++;
                $display("FAIL %s: addr %0d actual=0x%02h expected=0x%02h mask=0x%02h",
                         it.tag, it.addr, rd_data, it.exp[7:0], it.mask);
            end
        end
        mon_busy = 0;
    end

    initial begin
        repeat (200_000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", n_checks + 1, n_bad);
            $finish;
        end
    end

    initial begin
        run(3);
        rst_n = 1'b1;
        // R10 reset values
        exp_reg(3'd0, 8'hC0, 8'hFF, "R10 status after reset");
        exp_cnt(3'd1, 0, 0, "R10 hcount after reset");
        exp_cnt(3'd3, 0, 0, "R10 vcount after reset");
        exp_reg(3'd5, 8'h01, 8'hFF, "R10 ctrl after reset");
        drain();

        // normal: positive H period 8, positive V period 1000 clocks
        h_ph = 0; h_per = 8; h_hi = 2; h_en = 1;
        v_ph = 0; v_per = 1000; v_hi = 50; v_en = 1;
        run(RUN_CLKS);
        exp_reg(3'd0, 8'h0F, 8'hFF, "R9 R7 R8 normal status");
        exp_cnt(3'd1, WIN_CLKS / 8, 1, "R2 hcount period 8");
        exp_cnt(3'd3, 1000 / 2, 1, "R1 R6 vcount 500 ticks");
        drain();

        // standby: H absent, V negative polarity
        h_en = 0;
        v_hi = 950;
        run(RUN_CLKS);
        exp_reg(3'd0, 8'h42, 8'hFB, "R9 R8 standby status");
        exp_cnt(3'd1, 0, 0, "R2 hcount with no H");
        drain();

        // suspend: H negative polarity, V absent -> V overflow
        h_ph = 0; h_per = 8; h_hi = 6; h_en = 1;
        v_en = 0;
        run(RUN_CLKS);
        exp_reg(3'd0, 8'hA1, 8'hF7, "R9 R8 R6 suspend status");
        exp_cnt(3'd1, WIN_CLKS / 8, 1, "R2 hcount negative H");
        drain();
        reg_write(3'd6, 8'h00);
        exp_reg(3'd0, 8'h20, 8'h20, "R4 zero write keeps v overflow");
        drain();
        reg_write(3'd6, 8'h02);
        exp_reg(3'd0, 8'h00, 8'h20, "R4 v overflow cleared");
        drain();

        // horizontal overflow: period 4 gives more than 2^CNT_W pulses per window
        h_ph = 0; h_per = 4; h_hi = 2;
        run(RUN_CLKS);
        exp_reg(3'd0, 8'h10, 8'h10, "R3 h overflow set");
        exp_cnt(3'd1, (1 << CNT_W) - 1, 0, "R3 hcount saturates");
        drain();
        reg_write(3'd6, 8'h01);
        exp_reg(3'd0, 8'h00, 8'h10, "R4 h overflow cleared");
        drain();

        // horizontal enable off
        reg_write(3'd5, 8'h00);
        run(RUN_CLKS);
        exp_reg(3'd5, 8'h00, 8'hFF, "R5 ctrl readback");
        exp_cnt(3'd1, 0, 0, "R5 hcount held at zero");
        drain();

        // off: both absent
        h_en = 0; v_en = 0;
        run(RUN_CLKS);
        exp_reg(3'd0, 8'hC0, 8'hC3, "R9 R7 off status");
        drain();

        finished = 1;
        $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end
endmodule